// File: doc/BRIEF.md
# Periodic Interrupt and Flag Unit

This block sits beside the timekeeping core of a real-time clock. It takes a one-cycle enable that marks each tick of a 32.768 kHz time base. From that enable it makes a periodic event whose period is picked by a 4-bit rate code. It also takes one-cycle alarm and update-ended events from the clock core. Each of the three sources sets a sticky flag. A summary flag, which is also the interrupt request pin, is raised whenever a flag is set and its enable bit is set too.

Software reaches the block through a small byte-wide register port with three registers. The rate control register holds the time-base select and the rate code. The enable register holds the per-source enables and the square-wave enable. The flag register is read-only and clears itself when read. An optional square wave at the periodic rate is driven on its own pin.

Top module: `rtc_irq_unit`

## Requirements
- R1: After reset the rate control register reads 0x26, the enable register reads 0x00, the flag register reads 0x00, and irq and sqw are low.
- R2: reg_sel selects the register: 0 is rate control (bits 6-0 writable, bit 7 always reads 0), 1 is the enable register (all 8 bits writable), 2 is the flag register (writes are ignored), and 3 reads 0x00.
- R3: Rate control bits 3-0 hold the rate code. For codes 3 to 15 a periodic event occurs every 2^(code-1) ticks. A write to rate control restarts the count, so the first event lands on the 2^(code-1)-th tick after the write.
- R4: Rate codes 1 and 2 give the same periods as codes 8 and 9 (128 and 256 ticks).
- R5: No periodic event occurs when the rate code is 0 or when rate control bits 6-4 differ from 010.
- R6: The flag register bit 6 is set by a periodic event, bit 5 by alarm_evt and bit 4 by update_evt, whatever the enables hold. Flag bits 3-0 read 0.
- R7: Flag register bit 7 and the irq pin are high exactly when some flag is set and its enable is set. The enables are enable-register bit 6 for periodic, bit 5 for alarm and bit 4 for update-ended.
- R8: A read of the flag register returns its current value and then clears all flags. An event in the same cycle as the read stays set.
- R9: With enable-register bit 3 set and a nonzero rate code, sqw toggles every half period. It goes high half a period after the write to rate control. Otherwise sqw is low.
- R10: The periodic count and the square wave advance only in cycles where tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable per 32.768 kHz time-base period |
| alarm_evt | input | 1 | Alarm match pulse from the clock core |
| update_evt | input | 1 | Update-ended pulse from the clock core |
| reg_sel | input | 2 | Register select |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Read strobe (clears flags when reg_sel is 2) |
| rd_data | output | 8 | Read data, combinational from reg_sel |
| irq | output | 1 | Interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
The assertions check several rules on every cycle. No periodic event occurs while the rate is off or the time-base select is wrong, or outside a tick. Each event sets its flag on the next cycle. A clearing read with no event present empties the flag register. The square wave holds still when no tick arrives. The request pin rises only after an event or an enable write. The bench scenarios are needed for the rest: the exact period for each rate code, the aliasing of codes 1 and 2, the square-wave phase, the read-side values and the precedence of an event over a clearing read in the same cycle.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int RATE_W = 4;
  localparam int CNT_W  = (1 << RATE_W) - 2;   // longest period is 2^14 ticks
  localparam int PER_W  = CNT_W + 1;

  typedef enum logic [1:0] {
    SEL_RATE = 2'd0,
    SEL_ENA  = 2'd1,
    SEL_FLAG = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  // Codes 1 and 2 alias to 8 and 9; zero means off.
  function automatic logic [RATE_W-1:0] eff_code(input logic [RATE_W-1:0] code);
    if (code == '0) return '0;
    if (code < RATE_W'(3)) return code + RATE_W'(7);
    return code;
  endfunction

  // Period in ticks: 2^(eff-1), or 0 when off.
  function automatic logic [PER_W-1:0] period_ticks(input logic [RATE_W-1:0] code);
    logic [RATE_W-1:0] e;
    e = eff_code(code);
    if (e == '0) return '0;
    return PER_W'(1) << (e - RATE_W'(1));
  endfunction
endpackage

// File: rtl/rtc_irq_rate_gen.sv
module rtc_irq_rate_gen
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              restart,
  input  logic [RATE_W-1:0] rate,
  output logic              per_evt,
  output logic              sq_raw
);
  logic [CNT_W-1:0] cnt;
  logic [PER_W-1:0] period;
  logic [PER_W-1:0] half;
  logic             active;
  logic             at_last;
  logic             at_half;

  always_comb begin
    period  = period_ticks(rate);
    half    = period >> 1;
    active  = run && (rate != '0) && tick;
    at_last = (cnt == CNT_W'(period - PER_W'(1)));
    at_half = (cnt == CNT_W'(half - PER_W'(1)));
    per_evt = active && at_last;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt    <= '0;
      sq_raw <= 1'b0;
    end else if (active) begin
      cnt <= at_last ? '0 : cnt + CNT_W'(1);
      if (at_last || at_half) sq_raw <= ~sq_raw;
    end
  end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            clr,
  input  logic [NSRC-1:0] en_vec,
  output logic [NSRC-1:0] flags,
  output logic            req
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr)        flags[i] <= 1'b0;
    end
  end

  assign req = |(flags & en_vec);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_irq_pkg::*;
#(
  parameter logic [6:0] RESET_RATE = 7'h26,
  parameter logic [7:0] RESET_ENA  = 8'h00,
  parameter logic [2:0] BASE_SEL   = 3'b010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       alarm_evt,
  input  logic       update_evt,
  input  logic [1:0] reg_sel,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       sqw
);
  localparam int NSRC = 3;

  logic [6:0]        ctl_rate;
  logic [7:0]        ctl_ena;
  logic [RATE_W-1:0] rate;
  logic              run;
  logic              wr_rate;
  logic              wr_ena;
  logic              rd_clr;
  logic              per_evt;
  logic              sq_raw;
  logic [NSRC-1:0]   flags;
  logic              req;

  assign rate    = ctl_rate[RATE_W-1:0];
  assign run     = (ctl_rate[6:4] == BASE_SEL);
  assign wr_rate = wr_en && (reg_sel == SEL_RATE);
  assign wr_ena  = wr_en && (reg_sel == SEL_ENA);
  assign rd_clr  = rd_en && (reg_sel == SEL_FLAG);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_rate <= RESET_RATE;
      ctl_ena  <= RESET_ENA;
    end else begin
      if (wr_rate) ctl_rate <= wr_data[6:0];
      if (wr_ena)  ctl_ena  <= wr_data;
    end
  end

  rtc_irq_rate_gen u_rate (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .run     (run),
    .restart (wr_rate),
    .rate    (rate),
    .per_evt (per_evt),
    .sq_raw  (sq_raw)
  );

  rtc_irq_flags #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec ({per_evt, alarm_evt, update_evt}),
    .clr     (rd_clr),
    .en_vec  (ctl_ena[6:4]),
    .flags   (flags),
    .req     (req)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_RATE: rd_data = {1'b0, ctl_rate};
      SEL_ENA:  rd_data = ctl_ena;
      SEL_FLAG: rd_data = {req, flags, 4'b0000};
      default:  rd_data = 8'h00;
    endcase
  end

  assign irq = req;
  assign sqw = sq_raw && ctl_ena[3] && (rate != '0);
endmodule

// File: rtl/rtc_irq_unit_chk.sv
module rtc_irq_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       alarm_evt,
  input logic       update_evt,
  input logic       irq,
  input logic       run,
  input logic [3:0] rate,
  input logic       per_evt,
  input logic       sq_raw,
  input logic [2:0] flags,
  input logic       rd_clr,
  input logic       wr_rate,
  input logic       wr_ena
);
  a_r5_no_evt_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!run || rate == 4'd0) |-> !per_evt);

  a_r10_evt_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |-> tick);

  a_r10_sq_still: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_rate) |=> $stable(sq_raw));

  a_r6_per_sets: assert property (@(posedge clk) disable iff (!rst_n)
    per_evt |=> flags[2]);

  a_r6_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_evt |=> flags[1]);

  a_r6_update_sets: assert property (@(posedge clk) disable iff (!rst_n)
    update_evt |=> flags[0]);

  a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !per_evt && !alarm_evt && !update_evt) |=> (flags == 3'b000));

  a_r7_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(per_evt) || $past(alarm_evt) || $past(update_evt) || $past(wr_ena)));
endmodule

bind rtc_irq_unit rtc_irq_unit_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .alarm_evt  (alarm_evt),
  .update_evt (update_evt),
  .irq        (irq),
  .run        (run),
  .rate       (rate),
  .per_evt    (per_evt),
  .sq_raw     (sq_raw),
  .flags      (flags),
  .rd_clr     (rd_clr),
  .wr_rate    (wr_rate),
  .wr_ena     (wr_ena)
);

// File: tb/rtc_irq_unit_bench.sv
module rtc_irq_unit_bench;
  localparam int CLK_P = 10;
  localparam int NVEC  = 7;
  localparam logic [3:0] VEC_CODE [NVEC] = '{4'd3, 4'd4, 4'd5, 4'd6, 4'd1, 4'd2, 4'd7};
  localparam int         VEC_PER  [NVEC] = '{4, 8, 16, 32, 128, 256, 64};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b1;
  logic       tick_alt = 1'b0;
  logic       alarm_evt = 1'b0;
  logic       update_evt = 1'b0;
  logic [1:0] reg_sel = 2'd0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       irq;
  logic       sqw;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  rtc_irq_unit u_rtc_irq_unit (
    .clk(clk), .rst_n(rst_n), .tick(tick), .alarm_evt(alarm_evt),
    .update_evt(update_evt), .reg_sel(reg_sel), .wr_en(wr_en),
    .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .irq(irq), .sqw(sqw)
  );

  always #(CLK_P/2) clk = ~clk;

  always @(negedge clk) tick <= tick_alt ? ~tick : 1'b1;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [7:0] d);
    @(negedge clk);
    reg_sel = sel; rd_en = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic pulse(input bit is_alarm);
    @(negedge clk);
    if (is_alarm) alarm_evt = 1'b1; else update_evt = 1'b1;
    @(negedge clk);
    alarm_evt = 1'b0; update_evt = 1'b0;
  endtask

  // Quiet the rate, clear flags, then start the given rate control value.
  task automatic start_rate(input logic [7:0] a);
    logic [7:0] junk;
    wr(2'd0, 8'h20);
    rd(2'd2, junk);
    wr(2'd0, a);
  endtask

  // Cycles from the write edge until irq is seen high; -1 if never.
  task automatic measure(input int limit, output int k);
    k = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (irq) begin k = i; break; end
    end
  endtask

  initial begin
    #(CLK_P * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    logic [7:0] d;
    int k;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 sqw", sqw, 0);
    rd(2'd0, d); check("R1 rate reg", d, 8'h26);
    rd(2'd1, d); check("R1 enable reg", d, 8'h00);
    rd(2'd2, d); check("R1 flag reg", d, 8'h00);

    // R3/R4 table of rate codes and periods
    wr(2'd1, 8'h40);
    for (int v = 0; v < NVEC; v++) begin
      start_rate({4'h2, VEC_CODE[v]});
      measure(2000, k);
      check((VEC_CODE[v] < 4'd3) ? "R4 aliased period" : "R3 period", k, VEC_PER[v]);
    end

    // R3 longest period
    start_rate(8'h2F);
    measure(17000, k);
    check("R3 code 15 period", k, 16384);

    // R5 rate code zero and wrong time-base select
    start_rate(8'h20);
    measure(600, k);
    check("R5 code 0 no event", k, -1);
    start_rate(8'h03);
    measure(600, k);
    check("R5 base select off", k, -1);

    // R10 tick every other cycle doubles the cycle count
    tick_alt = 1'b1;
    start_rate(8'h23);
    measure(100, k);
    check("R10 gated tick", (k == 7 || k == 8) ? 1 : 0, 1);
    tick_alt = 1'b0;
    @(negedge clk);

    // R6/R7/R8 flags, enables and clear-on-read
    start_rate(8'h20);
    wr(2'd1, 8'h00);
    pulse(1'b1);
    check("R7 irq masked", irq, 0);
    rd(2'd2, d); check("R6 alarm flag", d, 8'h20);
    rd(2'd2, d); check("R8 cleared", d, 8'h00);
    pulse(1'b1);
    wr(2'd1, 8'h20);
    check("R7 irq enabled", irq, 1);
    rd(2'd2, d); check("R7 summary bit", d, 8'hA0);
    check("R8 irq after clear", irq, 0);
    wr(2'd1, 8'h10);
    pulse(1'b0);
    rd(2'd2, d); check("R6 update flag", d, 8'h90);

    // R8 event coincident with clearing read survives
    @(negedge clk);
    reg_sel = 2'd2; rd_en = 1'b1; alarm_evt = 1'b1;
    #1 d = rd_data;
    @(negedge clk);
    rd_en = 1'b0; alarm_evt = 1'b0;
    check("R8 read before event", d, 8'h00);
    rd(2'd2, d); check("R8 event kept", d, 8'h20);

    // R2 register map corners
    wr(2'd2, 8'hFF);
    rd(2'd2, d); check("R2 flag write ignored", d, 8'h00);
    rd(2'd3, d); check("R2 unused select", d, 8'h00);
    wr(2'd0, 8'hFF);
    rd(2'd0, d); check("R2 rate bit7 zero", d, 8'h7F);

    // R9 square wave, code 3: half period 2 cycles
    wr(2'd1, 8'h08);
    start_rate(8'h23);
    @(negedge clk); check("R9 sqw k1", sqw, 0);
    @(negedge clk); check("R9 sqw k2", sqw, 1);
    @(negedge clk); check("R9 sqw k3", sqw, 1);
    @(negedge clk); check("R9 sqw k4", sqw, 0);
    @(negedge clk);
    @(negedge clk); check("R9 sqw k6", sqw, 1);
    wr(2'd1, 8'h00);
    k = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (sqw) k++;
    end
    check("R9 sqw disabled low", k, 0);

    finish_up();
  end
endmodule